// File: doc/BRIEF.md
# Segment Descriptor Fetch and Decode Unit

This unit turns a 16-bit segment selector into a decoded descriptor. Bit 2 of the selector picks the global or the local table. The unit then checks the table bound and fetches the 8-byte entry as two 32-bit reads over a single-outstanding request/ready memory port. It splits the entry into base, limit, type, privilege, presence, default-size, granularity and gate fields, and flags entries that cannot be used.

When the caller sets the touch flag, the unit also checks that the segment is present. For code or data entries whose accessed flag is still clear, it re-reads the high word and writes it back with that flag set. Privilege policy and loading of the result into a segment register belong to the caller.

A run starts with a one-cycle `req_i` while the unit is idle. It ends with a one-cycle `done_o` and a status code: 0 success, 1 local table unusable, 2 null selector, 3 table bound exceeded, 4 unusable descriptor, 5 segment absent. Descriptor outputs hold their values until the next fetch.

Top module: `seg_fetch`

## Requirements
- R1: `rpl_o` equals selector bits [1:0]. Selector bit 2 set selects the local table (`ldt_*`), clear selects the global table (`gdt_*`). The byte offset is the selector with bits [2:0] cleared.
- R2: A global-table selector whose bits [15:3] are zero ends with status 2. A local-table selector while `ldt_valid_i` is low ends with status 1. Neither case issues any memory transaction.
- R3: When offset + 7 exceeds the selected table limit, the run ends with status 3 and no memory transaction. Offset + 7 equal to the limit is accepted.
- R4: The low word is read at table base + offset, then the high word at that address + 4. Only one transaction is outstanding, and request, address and write flag stay stable until `mem_ready_i`.
- R5: For code/data, LDT and TSS entries, `base_o` = {hi[31:24], hi[7:0], lo[31:16]}. The raw limit is {hi[19:16], lo[15:0]}. `type_o` = hi[11:8], `dpl_o` = hi[14:13], `present_o` = hi[15], `seg_o` = hi[12], `gran_o` = hi[23].
- R6: With hi[23] set, the limit is the raw limit shifted left by 12 with bits [11:0] all ones. Expand-down data (`seg_o`=1, type bit 3 clear, type bit 2 set) is the exception: its bits [11:0] stay zero.
- R7: Call, interrupt and trap gates (system types 4, 6, 7, 12, 14, 15) are usable only when hi[7:5] is zero, otherwise status 4. A usable gate gives `gate_sel_o` = lo[31:16], `gate_off_o` = {hi[31:16], lo[15:0]} and `gate_cnt_o` = hi[4:0].
- R8: A task gate (system type 5) is usable and gives `gate_sel_o` = lo[31:16]. System types 0, 8, 10 and 13 end with status 4. Code/data entries are always usable.
- R9: With touch set, a usable entry whose present bit hi[15] is clear ends with status 5. With touch clear, presence is not checked.
- R10: With touch set, a present code/data entry is re-read at offset + 4. If bit 8 of that word is clear, the word is written back to the same address with bit 8 set. No write happens when bit 8 is already set, for system entries, or when touch is clear.
- R11: After reset, `busy_o`, `done_o` and `mem_req_o` are low. `done_o` is a one-cycle pulse that ends every run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start pulse, taken while idle |
| selector_i | input | 16 | Selector to resolve |
| touch_i | input | 1 | Do presence check and accessed-flag update |
| gdt_base_i | input | ADDR_W | Global table base address |
| gdt_limit_i | input | ADDR_W | Global table limit (last valid byte) |
| ldt_valid_i | input | 1 | Local table descriptor is usable |
| ldt_base_i | input | ADDR_W | Local table base address |
| ldt_limit_i | input | ADDR_W | Local table limit |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Transaction completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (one cycle) |
| status_o | output | 3 | Result code |
| rpl_o | output | 2 | Requested privilege of the selector |
| base_o | output | 32 | Segment base |
| limit_o | output | 32 | Scaled segment limit |
| type_o | output | 4 | Descriptor type field |
| dpl_o | output | 2 | Descriptor privilege |
| present_o | output | 1 | Present bit |
| seg_o | output | 1 | Code/data (1) or system (0) |
| def32_o | output | 1 | 32-bit default size |
| gran_o | output | 1 | Page granularity |
| valid_o | output | 1 | Descriptor is usable |
| gate_sel_o | output | 16 | Gate target selector |
| gate_off_o | output | 32 | Gate target offset |
| gate_cnt_o | output | 5 | Gate parameter count |

## Verification
The bench places each table entry so that offset + 7 lands exactly on the limit, and the next entry so that it overshoots by one. An off-by-one bound compare therefore either rejects a legal entry or lets a fetch run past the table.

The bench counts memory transactions to catch an early exit that still reads memory. It expects a null selector to be rejected only in the global table. A design that ignored bit 2 here would refuse local entry 0.

Expand-down data with granularity must keep a zero-filled low limit, while code must come back all ones. Gates with any of hi[7:5] set must be refused. Each reserved type must be rejected.

The accessed-flag write is checked for address, data and count. A second touch must not write again, and a system entry must never be written.

// File: rtl/seg_fetch_pkg.sv
package seg_fetch_pkg;

  typedef enum logic [2:0] {
    ST_OK          = 3'd0,
    ST_LDT_BAD     = 3'd1,
    ST_NULL        = 3'd2,
    ST_LIMIT       = 3'd3,
    ST_BAD_DESC    = 3'd4,
    ST_NOT_PRESENT = 3'd5
  } seg_status_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic [3:0]  kind;
    logic [1:0]  dpl;
    logic        present;
    logic        seg;
    logic        def32;
    logic        gran;
    logic        valid;
    logic [15:0] gate_sel;
    logic [31:0] gate_off;
    logic [4:0]  gate_cnt;
  } seg_desc_t;

  localparam int unsigned ACC_BIT = 8;

endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [15:2]       sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] gdt_limit_i,
  input  logic              ldt_valid_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [ADDR_W-1:0] ldt_limit_i,
  output seg_status_e       status_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] tbl_base, tbl_lim;
  logic [ADDR_W:0]   last_byte;
  logic              use_ldt;

  always_comb begin
    off        = '0;
    off[15:3]  = sel_i[15:3];
    use_ldt    = sel_i[2];
    tbl_base   = use_ldt ? ldt_base_i  : gdt_base_i;
    tbl_lim    = use_ldt ? ldt_limit_i : gdt_limit_i;
    last_byte  = {1'b0, off} + (ADDR_W+1)'(7);
    addr_o     = tbl_base + off;
    if (use_ldt && !ldt_valid_i)                  status_o = ST_LDT_BAD;
    else if (!use_ldt && (sel_i[15:3] == '0))     status_o = ST_NULL;
    else if (last_byte > {1'b0, tbl_lim})         status_o = ST_LIMIT;
    else                                          status_o = ST_OK;
  end

endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_fetch_pkg::*;
(
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output seg_desc_t   desc_o
);

  logic [3:0]  typ;
  logic [31:0] raw_lim, base_raw;
  logic        unused_hi;

  assign typ       = hi_i[11:8];
  assign raw_lim   = {12'h000, hi_i[19:16], lo_i[15:0]};
  assign base_raw  = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
  assign unused_hi = ^hi_i[21:20];

  function automatic logic [31:0] scale(input logic [31:0] lim, input logic g, input logic fill);
    if (!g) return lim;
    return {lim[19:0], fill ? 12'hfff : 12'h000};
  endfunction

  always_comb begin
    desc_o         = '0;
    desc_o.kind    = typ;
    desc_o.dpl     = hi_i[14:13];
    desc_o.present = hi_i[15];
    desc_o.seg     = hi_i[12];
    desc_o.gran    = hi_i[23];
    if (hi_i[12]) begin
      desc_o.valid = 1'b1;
      desc_o.base  = base_raw;
      desc_o.def32 = hi_i[22];
      // expand-down data keeps a zero-filled low limit
      desc_o.limit = scale(raw_lim, hi_i[23], !(!typ[3] && typ[2]));
    end else begin
      unique case (typ)
        4'd2: begin
          desc_o.valid = 1'b1;
          desc_o.base  = base_raw;
          desc_o.limit = scale(raw_lim, hi_i[23], 1'b1);
        end
        4'd1, 4'd3, 4'd9, 4'd11: begin
          desc_o.valid = 1'b1;
          desc_o.base  = base_raw;
          desc_o.limit = scale(raw_lim, hi_i[23], 1'b1);
          desc_o.def32 = typ[3];
        end
        4'd5: begin
          desc_o.valid    = 1'b1;
          desc_o.gate_sel = lo_i[31:16];
        end
        4'd4, 4'd6, 4'd7, 4'd12, 4'd14, 4'd15: begin
          if (hi_i[7:5] == 3'b000) begin
            desc_o.valid    = 1'b1;
            desc_o.def32    = typ[3];
            desc_o.gate_sel = lo_i[31:16];
            desc_o.gate_off = {hi_i[31:16], lo_i[15:0]};
            desc_o.gate_cnt = hi_i[4:0];
          end
        end
        default: desc_o.valid = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [15:0]       selector_i,
  input  logic              touch_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] gdt_limit_i,
  input  logic              ldt_valid_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [ADDR_W-1:0] ldt_limit_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic [1:0]        rpl_o,
  output logic [31:0]       base_o,
  output logic [31:0]       limit_o,
  output logic [3:0]        type_o,
  output logic [1:0]        dpl_o,
  output logic              present_o,
  output logic              seg_o,
  output logic              def32_o,
  output logic              gran_o,
  output logic              valid_o,
  output logic [15:0]       gate_sel_o,
  output logic [31:0]       gate_off_o,
  output logic [4:0]        gate_cnt_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ_LO, S_READ_HI, S_DECODE, S_ACC_RD, S_ACC_WR, S_DONE
  } state_e;

  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);

  state_e            state_q;
  logic [15:0]       sel_q;
  logic              touch_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       lo_q, hi_q, acc_q;
  seg_status_e       status_q, chk_status;
  logic [ADDR_W-1:0] chk_addr;
  seg_desc_t         dec;
  logic              xfer;

  seg_sel_check #(.ADDR_W(ADDR_W)) i_sel_check (
    .sel_i       (sel_q[15:2]),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .ldt_valid_i (ldt_valid_i),
    .ldt_base_i  (ldt_base_i),
    .ldt_limit_i (ldt_limit_i),
    .status_o    (chk_status),
    .addr_o      (chk_addr)
  );

  seg_desc_decode i_decode (
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .desc_o (dec)
  );

  assign xfer = mem_req_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      sel_q    <= '0;
      touch_q  <= 1'b0;
      addr_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      acc_q    <= '0;
      status_q <= ST_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i) begin
          sel_q   <= selector_i;
          touch_q <= touch_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          status_q <= chk_status;
          addr_q   <= chk_addr;
          state_q  <= (chk_status == ST_OK) ? S_READ_LO : S_DONE;
        end
        S_READ_LO: if (xfer) begin
          lo_q    <= mem_rdata_i;
          state_q <= S_READ_HI;
        end
        S_READ_HI: if (xfer) begin
          hi_q    <= mem_rdata_i;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          if (!dec.valid) begin
            status_q <= ST_BAD_DESC;
            state_q  <= S_DONE;
          end else if (touch_q && !dec.present) begin
            status_q <= ST_NOT_PRESENT;
            state_q  <= S_DONE;
          end else if (touch_q && dec.seg) begin
            state_q  <= S_ACC_RD;
          end else begin
            state_q  <= S_DONE;
          end
        end
        // fresh re-read so the update does not clobber a concurrent change
        S_ACC_RD: if (xfer) begin
          acc_q   <= mem_rdata_i;
          state_q <= mem_rdata_i[ACC_BIT] ? S_DONE : S_ACC_WR;
        end
        S_ACC_WR: if (xfer) state_q <= S_DONE;
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q + HI_OFS;
    mem_wdata_o = acc_q | (32'd1 << ACC_BIT);
    unique case (state_q)
      S_READ_LO: begin mem_req_o = 1'b1; mem_addr_o = addr_q; end
      S_READ_HI, S_ACC_RD: mem_req_o = 1'b1;
      S_ACC_WR: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign status_o   = status_q;
  assign rpl_o      = sel_q[1:0];
  assign base_o     = dec.base;
  assign limit_o    = dec.limit;
  assign type_o     = dec.kind;
  assign dpl_o      = dec.dpl;
  assign present_o  = dec.present;
  assign seg_o      = dec.seg;
  assign def32_o    = dec.def32;
  assign gran_o     = dec.gran;
  assign valid_o    = dec.valid;
  assign gate_sel_o = dec.gate_sel;
  assign gate_off_o = dec.gate_off;
  assign gate_cnt_o = dec.gate_cnt;

endmodule

// File: rtl/seg_fetch_chk.sv
module seg_fetch_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [2:0]        status_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_wdata_acc,
  input logic              mem_ready_i,
  input logic              gran_o,
  input logic              seg_o,
  input logic [3:0]        type_o,
  input logic [11:0]       limit_lo,
  input logic              valid_o,
  input logic              present_o
);

  logic [2:0] xfer_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   xfer_cnt <= '0;
    else if (req_i && !busy_o)     xfer_cnt <= '0;
    else if (mem_req_o && mem_ready_i && xfer_cnt != 3'd7) xfer_cnt <= xfer_cnt + 3'd1;
  end

  // R2 R3
  early_exit_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (status_o inside {3'd1, 3'd2, 3'd3}) |-> xfer_cnt == 3'd0);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R10
  acc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && mem_wdata_acc);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  gran_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == 3'd0 && seg_o && gran_o && !(!type_o[3] && type_o[2])
    |-> limit_lo == 12'hfff);

  // R8
  ok_is_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == 3'd0 |-> valid_o);

  // R9
  absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == 3'd5 |-> !present_o);

endmodule

bind seg_fetch seg_fetch_chk #(.ADDR_W(ADDR_W)) i_seg_fetch_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .status_o      (status_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_acc (mem_wdata_o[8]),
  .mem_ready_i   (mem_ready_i),
  .gran_o        (gran_o),
  .seg_o         (seg_o),
  .type_o        (type_o),
  .limit_lo      (limit_o[11:0]),
  .valid_o       (valid_o),
  .present_o     (present_o)
);

// File: tb/test_seg_fetch.sv
module test_seg_fetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, touch = 1'b0, ldt_ok = 1'b0;
  logic [15:0] sel = '0;
  logic        mem_req, mem_we, busy, done, present, seg, def32, gran, valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, base, limit, gate_off;
  logic        mem_ready;
  logic [2:0]  status;
  logic [1:0]  rpl, dpl;
  logic [3:0]  typ;
  logic [15:0] gate_sel;
  logic [4:0]  gate_cnt;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd = '0, prev_rd = '0, last_wr = '0;
  logic rdy_tgl = 1'b0;
  logic [31:0] mem [0:63];

  always #5 clk = ~clk;

  assign mem_ready = rdy_tgl;
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    rdy_tgl <= ~rdy_tgl;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt  <= wr_cnt + 1;
        last_wr <= mem_addr;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        prev_rd <= last_rd;
        last_rd <= mem_addr;
      end
    end
  end

  seg_fetch #(.ADDR_W(32)) i_seg_fetch (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .selector_i(sel), .touch_i(touch),
    .gdt_base_i(32'h0), .gdt_limit_i(32'h3f), .ldt_valid_i(ldt_ok),
    .ldt_base_i(32'h80), .ldt_limit_i(32'h1f),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .status_o(status), .rpl_o(rpl), .base_o(base),
    .limit_o(limit), .type_o(typ), .dpl_o(dpl), .present_o(present), .seg_o(seg),
    .def32_o(def32), .gran_o(gran), .valid_o(valid), .gate_sel_o(gate_sel),
    .gate_off_o(gate_off), .gate_cnt_o(gate_cnt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] addr, input logic [31:0] lo, input logic [31:0] hi);
    mem[addr[7:2]]      = lo;
    mem[addr[7:2] + 1]  = hi;
  endtask

  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] t, input logic s, input logic p, input logic g, input logic [1:0] d);
    return {b[31:24], g, 1'b0, 2'b00, l[19:16], p, d, s, t, b[23:16]};
  endfunction

  task automatic run(input logic [15:0] s, input logic t);
    @(negedge clk);
    sel = s; touch = t; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 busy after reset", 32'(busy), 0);
    check("R11 done after reset", 32'(done), 0);
    check("R11 mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_early_exits;
    int r0;
    r0 = rd_cnt;
    run(16'h0003, 1'b0);
    check("R2 null status", 32'(status), 2);
    check("R1 rpl", 32'(rpl), 3);
    ldt_ok = 1'b0;
    run(16'h000c, 1'b0);
    check("R2 ldt unusable status", 32'(status), 1);
    run(16'h0040, 1'b0);
    check("R3 limit status", 32'(status), 3);
    check("R2 R3 no reads", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_data_fetch;
    int r0, w0;
    put(8'h08, {16'h5678, 16'hbcde}, mk_hi(32'h12345678, 20'habcde, 4'h2, 1, 1, 0, 2'd2));
    r0 = rd_cnt; w0 = wr_cnt;
    run(16'h000a, 1'b0);
    check("R5 status ok", 32'(status), 0);
    check("R5 base", base, 32'h12345678);
    check("R5 limit", limit, 32'h000abcde);
    check("R5 dpl", 32'(dpl), 2);
    check("R5 type", 32'(typ), 2);
    check("R1 rpl", 32'(rpl), 2);
    check("R4 two reads", 32'(rd_cnt - r0), 2);
    check("R4 low addr", prev_rd, 32'h08);
    check("R4 high addr", last_rd, 32'h0c);
    check("R10 no write when touch clear", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_gran;
    put(8'h10, {16'h0, 16'h0012}, mk_hi(32'h0, 20'h00012, 4'ha, 1, 1, 1, 2'd0));
    put(8'h18, {16'h0, 16'h0012}, mk_hi(32'h0, 20'h00012, 4'h6, 1, 1, 1, 2'd0));
    run(16'h0010, 1'b0);
    check("R6 code gran fill", limit, 32'h00012fff);
    run(16'h0018, 1'b0);
    check("R6 expand-down gran no fill", limit, 32'h00012000);
  endtask

  task automatic t_touch;
    int w0;
    w0 = wr_cnt;
    run(16'h0008, 1'b1);
    check("R10 status", 32'(status), 0);
    check("R10 one write", 32'(wr_cnt - w0), 1);
    check("R10 write addr", last_wr, 32'h0c);
    check("R10 accessed bit set", 32'(mem[3][8]), 1);
    w0 = wr_cnt;
    run(16'h0008, 1'b1);
    check("R10 no rewrite", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_absent;
    int w0;
    put(8'h20, 32'h0, mk_hi(32'h0, 20'h1, 4'h2, 1, 0, 0, 2'd0));
    w0 = wr_cnt;
    run(16'h0020, 1'b1);
    check("R9 absent status", 32'(status), 5);
    run(16'h0020, 1'b0);
    check("R9 no check without touch", 32'(status), 0);
    check("R9 no write", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_gates;
    put(8'h28, {16'h0028, 16'hbeef}, {16'hdead, 1'b1, 2'd3, 1'b0, 4'hc, 3'b000, 5'd3});
    run(16'h0028, 1'b0);
    check("R7 gate status", 32'(status), 0);
    check("R7 gate sel", 32'(gate_sel), 32'h0028);
    check("R7 gate off", gate_off, 32'hdeadbeef);
    check("R7 gate cnt", 32'(gate_cnt), 3);
    put(8'h28, {16'h0028, 16'hbeef}, {16'hdead, 1'b1, 2'd3, 1'b0, 4'h6, 3'b010, 5'd3});
    run(16'h0028, 1'b0);
    check("R7 gate bad bits", 32'(status), 4);
    put(8'h30, {16'h0030, 16'h0}, {16'h0, 1'b1, 2'd0, 1'b0, 4'h5, 8'h0});
    run(16'h0030, 1'b0);
    check("R8 task gate status", 32'(status), 0);
    check("R8 task gate sel", 32'(gate_sel), 32'h0030);
    foreach (bad_types[i]) begin
      put(8'h30, 32'h0, {16'h0, 1'b1, 2'd0, 1'b0, bad_types[i], 8'h0});
      run(16'h0030, 1'b0);
      check("R8 reserved type", 32'(status), 4);
    end
  endtask

  logic [3:0] bad_types [4] = '{4'd0, 4'd8, 4'd10, 4'd13};

  task automatic t_boundary_ldt;
    int w0;
    put(8'h38, 32'h0000_ffff, mk_hi(32'h0, 20'hffff, 4'h2, 1, 1, 0, 2'd0));
    run(16'h0038, 1'b0);
    check("R3 last entry accepted", 32'(status), 0);
    ldt_ok = 1'b1;
    put(8'h80, {16'h1111, 16'h0001}, mk_hi(32'h00001111, 20'h1, 4'h3, 1, 1, 0, 2'd0));
    put(8'h88, {16'h2222, 16'h0002}, mk_hi(32'h00002222, 20'h2, 4'h3, 1, 1, 0, 2'd3));
    run(16'h0004, 1'b0);
    check("R2 ldt entry 0 not null", 32'(status), 0);
    check("R1 ldt entry 0 base", base, 32'h1111);
    run(16'h000c, 1'b0);
    check("R1 ldt base", base, 32'h2222);
    check("R4 ldt low addr", prev_rd, 32'h88);
    run(16'h0024, 1'b0);
    check("R3 ldt limit", 32'(status), 3);
    put(8'h18, 32'h0, mk_hi(32'h0, 20'h10, 4'h2, 0, 1, 0, 2'd0));
    w0 = wr_cnt;
    run(16'h0018, 1'b1);
    check("R10 system entry no write", 32'(wr_cnt - w0), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_early_exits();
    t_data_fetch();
    t_gran();
    t_touch();
    t_absent();
    t_gates();
    t_boundary_ldt();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule